// File: doc/BRIEF.md
# Serial LED Status Shifter

This block gathers three indicator bits from each of eight ports and sends them to external shift registers over a two-wire serial link: a clock and a data line. One burst carries 24 bits. Each bit gets one clock pulse with a fixed uneven shape: a short high phase and a long low phase. The bits are stored in a shadow register when a burst starts, so a burst always shows one consistent picture even if the port status changes while it is being sent. After the last pulse the clock stays low for a long idle gap. The receiving logic uses that gap as its frame marker, so there is no separate latch strobe.

Each port provides four status inputs: link/activity lit, speed-is-100, full duplex and collision. From these the block builds three LED bits per port: link/activity, speed and duplex/collision. All LED bits are active low. With a 25 MHz system clock, the default counts give a 40 ns high phase, a 600 ns low phase and a 40 ms gap.

The controller is a three-state machine:
- GAP is the idle period. Both outputs are low and it lasts GAP_CYC cycles.
- LOW presents a data bit with the clock low for LOW_CYC cycles.
- HIGH raises the clock for HIGH_CYC cycles.

The transitions are:
- GAP→LOW when the gap timer expires. The frame is captured on this same edge.
- LOW→HIGH when the low timer expires.
- HIGH→LOW when the high timer expires and bits remain. The bit index advances.
- HIGH→GAP when the high timer expires after the last bit.

Top module: `led_status_serializer`

## Requirements
- R1: While reset is asserted, the LED clock and LED data outputs are both low.
- R2: After reset is released, the first burst begins only after one full idle gap of GAP_CYC cycles. Both outputs stay low during that gap.
- R3: Every serial clock pulse is high for exactly HIGH_CYC system cycles. Every pulse is preceded by a low phase of exactly LOW_CYC cycles. The defaults are 1 and 15.
- R4: Each burst contains exactly 3×NUM_PORTS clock pulses, which is 24 by default.
- R5: After the last pulse of a burst, the clock and data stay low for exactly GAP_CYC cycles (default 1,000,000) before the next burst starts.
- R6: Bit position b in a burst, counted from 0, belongs to port b/3. Its field is b mod 3, where 0 is link/activity, 1 is speed and 2 is duplex/collision. Port 0 is sent first.
- R7: The LED bits are active low. The link/activity bit is 0 when that port's link/activity input is 1. The speed bit is 0 when that port's speed-is-100 input is 1.
- R8: The duplex/collision bit is 0 (lit) whenever the port is full duplex. In half duplex it is 0 only while the collision input is 1.
- R9: The data line changes only while the clock is low: either on the clock's falling edge or on entry to a burst from the gap. It never changes during a high phase.
- R10: The 24 bits are captured on the cycle the gap ends. Input changes during a burst have no effect on that burst and appear in the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_link_act | input | NUM_PORTS | Per-port link/activity lamp request, 1 = lit |
| port_speed_100 | input | NUM_PORTS | Per-port speed, 1 = 100M |
| port_full_duplex | input | NUM_PORTS | Per-port duplex, 1 = full |
| port_collision | input | NUM_PORTS | Per-port collision in progress |
| led_clk | output | 1 | Serial LED clock |
| led_data | output | 1 | Serial LED data, active low |

## Verification
Each fault in the state machine or its counters shows up at the outputs in a predictable way:
- A timer off by one cycle moves a clock edge. The per-cycle comparison catches this on the first pulse after the error, at most LOW_CYC+HIGH_CYC cycles later.
- A faulty bit index shifts or repeats bits on the data line, or changes the pulse count. This is visible within the burst it corrupts, and the pulse count is checked when the burst enters the gap.
- A shadow register that is not captured, or that follows the inputs live, shows the wrong level. This is exposed by the first bit whose input changed after the capture edge.

// File: rtl/led_ser_pkg.sv
`timescale 1ns/1ps
package led_ser_pkg;

    typedef enum logic [1:0] {
        ST_GAP  = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } ser_state_e;

    localparam int FIELDS_PER_PORT = 3;
    localparam int FLD_LINK   = 0;
    localparam int FLD_SPEED  = 1;
    localparam int FLD_DUPCOL = 2;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/led_phase_timer.sv
`timescale 1ns/1ps
module led_phase_timer
    import led_ser_pkg::*;
#(
    parameter int HIGH_CYC = 1,
    parameter int LOW_CYC  = 15,
    parameter int GAP_CYC  = 1000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  ser_state_e state,
    output logic       done
);
    localparam int MAX_CYC = max3(HIGH_CYC, LOW_CYC, GAP_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_val;

    always_comb begin
        unique case (state)
            ST_GAP:  last_val = CNT_W'(GAP_CYC - 1);
            ST_LOW:  last_val = CNT_W'(LOW_CYC - 1);
            ST_HIGH: last_val = CNT_W'(HIGH_CYC - 1);
            default: last_val = '0;
        endcase
    end

    assign done = (cnt == last_val);

    // The phase changes exactly when done is seen, so the counter restarts then.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (done) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    // R3: a new phase always starts its count from zero
    p_restart_after_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(done) |-> (cnt == '0));

    // R3: count never runs beyond the active phase length
    p_count_in_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last_val);

endmodule

// File: rtl/led_bit_index.sv
`timescale 1ns/1ps
module led_bit_index #(
    parameter int NUM_BITS = 24
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clear,
    input  logic                        step,
    output logic [$clog2(NUM_BITS)-1:0] idx,
    output logic                        last
);
    localparam int IDX_W = $clog2(NUM_BITS);

    assign last = (idx == IDX_W'(NUM_BITS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             idx <= '0;
        else if (clear)         idx <= '0;
        else if (step && last)  idx <= '0;
        else if (step)          idx <= idx + 1'b1;
    end

    // R6: bits are walked in ascending order, one per clock pulse
    p_idx_ascends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(step) && !$past(last) && !$past(clear)) |-> (idx == $past(idx) + 1'b1));

    // R6: index holds between pulses
    p_idx_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(step) && !$past(clear)) |-> $stable(idx));

endmodule

// File: rtl/led_frame_capture.sv
`timescale 1ns/1ps
module led_frame_capture
    import led_ser_pkg::*;
#(
    parameter int NUM_PORTS = 8
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          capture,
    input  logic [NUM_PORTS-1:0]                          link_act,
    input  logic [NUM_PORTS-1:0]                          speed_100,
    input  logic [NUM_PORTS-1:0]                          full_duplex,
    input  logic [NUM_PORTS-1:0]                          collision,
    input  logic [$clog2(NUM_PORTS*FIELDS_PER_PORT)-1:0]  sel,
    output logic                                          bit_out
);
    localparam int NUM_BITS = NUM_PORTS * FIELDS_PER_PORT;

    logic [NUM_BITS-1:0] frame_now;
    logic [NUM_BITS-1:0] shadow;

    // Active-low lamp encoding, port 0 in the lowest positions.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic dupcol_lit;
        assign dupcol_lit = full_duplex[p] | collision[p];
        assign frame_now[p*FIELDS_PER_PORT + FLD_LINK]   = ~link_act[p];
        assign frame_now[p*FIELDS_PER_PORT + FLD_SPEED]  = ~speed_100[p];
        assign frame_now[p*FIELDS_PER_PORT + FLD_DUPCOL] = ~dupcol_lit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       shadow <= '0;
        else if (capture) shadow <= frame_now;
    end

    assign bit_out = shadow[sel];

    // R10: shadow is frozen outside the capture cycle
    p_shadow_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(capture) |-> $stable(shadow));

    // R10: capture takes the live status of that cycle
    p_shadow_loaded_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(capture) |-> (shadow == $past(frame_now)));

endmodule

// File: rtl/led_status_serializer.sv
`timescale 1ns/1ps
module led_status_serializer
    import led_ser_pkg::*;
#(
    parameter int NUM_PORTS = 8,
    parameter int HIGH_CYC  = 1,
    parameter int LOW_CYC   = 15,
    parameter int GAP_CYC   = 1000000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] port_link_act,
    input  logic [NUM_PORTS-1:0] port_speed_100,
    input  logic [NUM_PORTS-1:0] port_full_duplex,
    input  logic [NUM_PORTS-1:0] port_collision,
    output logic                 led_clk,
    output logic                 led_data
);
    localparam int NUM_BITS = NUM_PORTS * FIELDS_PER_PORT;
    localparam int IDX_W    = $clog2(NUM_BITS);

    ser_state_e       state;
    ser_state_e       state_nx;
    logic             tmr_done;
    logic             capture;
    logic             bit_step;
    logic             bit_last;
    logic [IDX_W-1:0] bit_idx;
    logic             frame_bit;

    led_phase_timer #(
        .HIGH_CYC (HIGH_CYC),
        .LOW_CYC  (LOW_CYC),
        .GAP_CYC  (GAP_CYC)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .state (state),
        .done  (tmr_done)
    );

    led_bit_index #(
        .NUM_BITS (NUM_BITS)
    ) u_index (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (capture),
        .step  (bit_step),
        .idx   (bit_idx),
        .last  (bit_last)
    );

    led_frame_capture #(
        .NUM_PORTS (NUM_PORTS)
    ) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (capture),
        .link_act    (port_link_act),
        .speed_100   (port_speed_100),
        .full_duplex (port_full_duplex),
        .collision   (port_collision),
        .sel         (bit_idx),
        .bit_out     (frame_bit)
    );

    assign capture  = (state == ST_GAP)  && tmr_done;
    assign bit_step = (state == ST_HIGH) && tmr_done;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_GAP:  if (tmr_done) state_nx = ST_LOW;
            ST_LOW:  if (tmr_done) state_nx = ST_HIGH;
            ST_HIGH: if (tmr_done) state_nx = bit_last ? ST_GAP : ST_LOW;
            default: state_nx = ST_GAP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_GAP;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_GAP:  begin led_clk = 1'b0; led_data = 1'b0;      end
            ST_LOW:  begin led_clk = 1'b0; led_data = frame_bit; end
            ST_HIGH: begin led_clk = 1'b1; led_data = frame_bit; end
            default: begin led_clk = 1'b0; led_data = 1'b0;      end
        endcase
    end

    // R3: clock rises only at the end of a full low phase
    p_rise_after_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(led_clk) |-> ($past(state) == ST_LOW && $past(tmr_done)));

    // R9: data moves only while the clock is low
    p_data_moves_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(led_data) |-> !led_clk);

    // R4: the gap is entered only after the last bit's pulse
    p_gap_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP && $past(state) == ST_HIGH) |-> $past(bit_last));

    // R5: a burst starts only from an expired gap
    p_burst_from_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOW && $past(state) == ST_GAP) |-> $past(tmr_done));

endmodule

// File: tb/led_status_serializer_bench.sv
`timescale 1ns/1ps
module led_status_serializer_bench;
    localparam int CLK_PERIOD = 40;
    localparam int NP   = 8;
    localparam int HC   = 1;
    localparam int LC   = 15;
    localparam int GC   = 100;
    localparam int NB   = NP * 3;
    localparam int BIT_CYC = HC + LC;
    localparam int PER  = GC + NB * BIT_CYC;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NP-1:0] link_act, speed_100, full_dup, collision;
    logic          led_clk, led_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    led_status_serializer #(
        .NUM_PORTS (NP),
        .HIGH_CYC  (HC),
        .LOW_CYC   (LC),
        .GAP_CYC   (GC)
    ) u_led_status_serializer (
        .clk              (clk),
        .rst_n            (rst_n),
        .port_link_act    (link_act),
        .port_speed_100   (speed_100),
        .port_full_duplex (full_dup),
        .port_collision   (collision),
        .led_clk          (led_clk),
        .led_data         (led_data)
    );

    function automatic logic [NB-1:0] lamp_frame();
        logic [NB-1:0] f;
        for (int p = 0; p < NP; p++) begin
            f[3*p]   = !link_act[p];
            f[3*p+1] = !speed_100[p];
            f[3*p+2] = !(full_dup[p] || (!full_dup[p] && collision[p]));
        end
        return f;
    endfunction

    // Reference model: cycles since reset release, burst snapshots in a queue.
    int            k = 0;
    logic [NB-1:0] snap_q[$];
    logic [NB-1:0] snap;
    int            pulses = 0;
    logic          prev_clk = 1'b0;
    logic          prev_data = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp_v);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at t=%0t: actual=%0d expected=%0d", tag, $time, act, exp_v);
        end
    endtask

    always @(posedge clk) begin
        int m, j, b, r;
        logic e_clk, e_data;
        string tag;
        if (!rst_n) begin
            k = 0;
            pulses = 0;
        end else begin
            k = k + 1;
            if (k % PER == GC) snap_q.push_back(lamp_frame());
        end
        #(CLK_PERIOD/4);
        if (!rst_n || k == 0) begin
            check(led_clk == 1'b0 && led_data == 1'b0, "R1 reset quiet",
                  {led_clk, led_data}, 0);
        end else begin
            m = k % PER;
            if (m < GC) begin
                e_clk = 1'b0; e_data = 1'b0;
                tag = (k < GC) ? "R2 first idle gap" : "R5 idle gap";
                check(led_clk == e_clk && led_data == e_data, tag,
                      {led_clk, led_data}, 0);
                if (m == 0) begin
                    check(pulses == NB, "R4 pulses per burst", pulses, NB);
                    pulses = 0;
                    if (snap_q.size() > 0) void'(snap_q.pop_front());
                end
            end else begin
                j = m - GC;
                b = j / BIT_CYC;
                r = j % BIT_CYC;
                e_clk = (r >= LC);
                snap = (snap_q.size() > 0) ? snap_q[0] : '0;
                e_data = snap[b];
                check(led_clk == e_clk, "R3 clock shape", led_clk, e_clk);
                case (b % 3)
                    0: tag = "R6 R7 R10 link bit";
                    1: tag = "R6 R7 R10 speed bit";
                    default: tag = "R6 R8 R10 dupcol bit";
                endcase
                check(led_data == e_data, tag, led_data, e_data);
                if (led_clk && !prev_clk) pulses++;
            end
            if (led_data != prev_data)
                check(!led_clk, "R9 data change while high", led_clk, 0);
        end
        prev_clk  = led_clk;
        prev_data = led_data;
    end

    task automatic drive(input logic [NP-1:0] la, input logic [NP-1:0] sp,
                         input logic [NP-1:0] fd, input logic [NP-1:0] co);
        @(negedge clk);
        link_act = la; speed_100 = sp; full_dup = fd; collision = co;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        link_act = '1; speed_100 = '1; full_dup = '1; collision = '0;
        wait_cyc(5);
        rst_n = 1'b1;
        // all lamps lit, first burst after the idle gap (R2, R7, R8)
        wait_cyc(GC + 150);
        // change mid-burst: must not disturb current burst (R10)
        drive(8'hA5, 8'h3C, 8'h0F, 8'hF0);
        wait_cyc(PER + 20);
        // all dark, half duplex no collision (R7, R8)
        drive('0, '0, '0, '0);
        wait_cyc(PER);
        // half duplex with collision on odd ports (R8)
        drive(8'h55, 8'hAA, 8'h00, 8'hAA);
        wait_cyc(PER);
        // walking single port (R6)
        for (int p = 0; p < NP; p += 3) begin
            drive(NP'(1) << p, NP'(1) << (NP-1-p), NP'(1) << p, '0);
            wait_cyc(PER / 2);
        end
        wait_cyc(PER);
        // reset in the middle of a burst (R1, R2)
        wait_cyc(GC + 40);
        @(negedge clk);
        rst_n = 1'b0;
        wait_cyc(4);
        rst_n = 1'b1;
        snap_q.delete();
        drive(8'h0F, 8'hF0, 8'h33, 8'hCC);
        wait_cyc(2 * PER + 10);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule